// File: doc/BRIEF.md
# Debounced GPIO port controller

A 32-pin general-purpose I/O port reached through a simple 32-bit word-addressed register bus. Software sets an output data word, a direction word (a set bit makes the pin an output) and an open-drain select word. It reads the pin levels back through a status word. Every input first passes a two-flop synchronizer.

Each pin can have its own debounce filter. A shared prescaler produces a single-cycle tick every 50 µs; the clock count per tick is a parameter. A pin with filtering enabled reports a new level only after the synchronized input has differed from the reported level on a number of consecutive ticks equal to that pin's 16-bit threshold. Any return to the reported level restarts that pin's count. Two interrupt-enable locations are kept as plain storage. No interrupt logic exists behind them.

Top module: `dbgpio_port`

## Requirements
- R1: After reset every register reads zero and no pad is driven: `pad_oe_o` is 0, every pin is an input, drive is push-pull and filtering is off.
- R2: The output data word (offset 0x00) and the direction word (offset 0x0C, 1 = output) read back as written. A push-pull output pin drives `pad_o` equal to its data bit with `pad_oe_o` set, from the cycle after the write.
- R3: For a pin whose bit is set in the open-drain word (offset 0x1C), output data 0 asserts `pad_oe_o` with `pad_o` low. Output data 1 deasserts `pad_oe_o`, and `pad_o` is never high.
- R4: A pin whose direction bit is 0 never asserts `pad_oe_o`, whatever its data and open-drain bits.
- R5: With filtering off, the status word (offset 0x04) returns the pad level synchronized through two flops. A pad change can be read on a read issued three cycles later.
- R6: With the pin's bit set in the debounce-enable word (offset 0x18), the status bit takes the new input level only after the input has differed from the reported level on as many consecutive ticks as the threshold (one tick every CLKS_PER_TICK cycles).
- R7: A filtered pin whose input returns to the reported level before the threshold is reached keeps its reported level, and its tick count restarts from zero.
- R8: Pin n's threshold lives at offset 0x80 + 4·n. It holds 16 bits (bits 15:0), reads back with bits 31:16 as zero, and each pin's value is independent of the others.
- R9: Offsets 0x10 and 0x14 store and return a full 32-bit word. Offset 0x08 always reads zero.
- R10: Reads of unmapped offsets return zero. Writes to unmapped offsets and to the status word change no register and no pad output.
- R11: Clearing a pin's debounce-enable bit makes its status follow the synchronized input again at once, whatever its threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| pad_i | input | 32 | Pad input levels |
| pad_o | output | 32 | Pad output levels |
| pad_oe_o | output | 32 | Pad output enables |

## Verification
The bench goes after the filter's count rule with input glitches shorter than the threshold, repeated several times in a row. A filter that failed to restart its count would add up the ticks of the separate glitches and flip the status bit. Sustained changes in both directions are read once before the earliest legal switch and once after the latest, so a filter that counted one tick too few or too many shows up in the first or the second read. Open-drain drive is swept against several data patterns, because a design that drove high in that mode would show `pad_o` high with the enable set. Writes to the status word and to unmapped offsets are followed by readback of every writable register and of the pad outputs, to catch a decode that aliases.

// File: rtl/dbgpio_pkg.sv
package dbgpio_pkg;
  localparam int OFS_DOUT  = 'h00;
  localparam int OFS_STAT  = 'h04;
  localparam int OFS_ISTAT = 'h08;
  localparam int OFS_DIR   = 'h0C;
  localparam int OFS_RSV0  = 'h10;
  localparam int OFS_RSV1  = 'h14;
  localparam int OFS_DBEN  = 'h18;
  localparam int OFS_ODEN  = 'h1C;
  localparam int OFS_THR   = 'h80;
endpackage

// File: rtl/dbgpio_tick.sv
module dbgpio_tick #(
  parameter int unsigned CLKS_PER_TICK = 12500
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (CLKS_PER_TICK <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_count
      localparam int unsigned CW = $clog2(CLKS_PER_TICK);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else if (cnt_q == CW'(CLKS_PER_TICK - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(CLKS_PER_TICK - 1));
    end
  endgenerate
endmodule

// File: rtl/dbgpio_sync.sv
module dbgpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/dbgpio_filter.sv
module dbgpio_filter #(
  parameter int unsigned THR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             raw_i,
  output logic             filt_o
);
  logic             filt_q;
  logic [THR_W-1:0] cnt_q;
  logic [THR_W:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!en_i) begin
      filt_q <= raw_i;
      cnt_q  <= '0;
    end else if (raw_i == filt_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_nx >= {1'b0, thr_i}) begin
        filt_q <= raw_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_nx[THR_W-1:0];
      end
    end
  end
  assign filt_o = filt_q;
endmodule

// File: rtl/dbgpio_regs.sv
module dbgpio_regs
  import dbgpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned THR_W    = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_i,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  input  logic [NUM_PINS-1:0]             status_i,
  output logic [NUM_PINS-1:0]             dout_o,
  output logic [NUM_PINS-1:0]             dir_o,
  output logic [NUM_PINS-1:0]             od_o,
  output logic [NUM_PINS-1:0]             dben_o,
  output logic [NUM_PINS-1:0][THR_W-1:0]  thr_o
);
  localparam int unsigned IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [NUM_PINS-1:0] dout_q, dir_q, od_q, dben_q;
  logic [DATA_W-1:0]   rsv0_q, rsv1_q, rd_d, rdata_q;
  logic [NUM_PINS-1:0][THR_W-1:0] thr_q;
  logic [ADDR_W-1:0]   thr_ofs;
  logic [IDX_W-1:0]    thr_idx;
  logic                thr_hit, wr;

  assign wr      = req_i & we_i;
  assign thr_ofs = addr_i - ADDR_W'(OFS_THR);
  assign thr_idx = thr_ofs[IDX_W+1:2];
  assign thr_hit = (addr_i >= ADDR_W'(OFS_THR)) && (addr_i[1:0] == 2'b00)
                && ((thr_ofs >> 2) < ADDR_W'(NUM_PINS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      dir_q  <= '0;
      od_q   <= '0;
      dben_q <= '0;
      rsv0_q <= '0;
      rsv1_q <= '0;
    end else if (wr) begin
      case (addr_i)
        ADDR_W'(OFS_DOUT): dout_q <= wdata_i[NUM_PINS-1:0];
        ADDR_W'(OFS_DIR):  dir_q  <= wdata_i[NUM_PINS-1:0];
        ADDR_W'(OFS_ODEN): od_q   <= wdata_i[NUM_PINS-1:0];
        ADDR_W'(OFS_DBEN): dben_q <= wdata_i[NUM_PINS-1:0];
        ADDR_W'(OFS_RSV0): rsv0_q <= wdata_i;
        ADDR_W'(OFS_RSV1): rsv1_q <= wdata_i;
        default: ;
      endcase
    end
  end

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_thr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) thr_q[p] <= '0;
        else if (wr && thr_hit && (thr_idx == IDX_W'(p))) thr_q[p] <= wdata_i[THR_W-1:0];
      end
    end
  endgenerate

  always_comb begin
    rd_d = '0;
    if (thr_hit) begin
      rd_d[THR_W-1:0] = thr_q[thr_idx];
    end else begin
      case (addr_i)
        ADDR_W'(OFS_DOUT): rd_d[NUM_PINS-1:0] = dout_q;
        ADDR_W'(OFS_STAT): rd_d[NUM_PINS-1:0] = status_i;
        ADDR_W'(OFS_DIR):  rd_d[NUM_PINS-1:0] = dir_q;
        ADDR_W'(OFS_ODEN): rd_d[NUM_PINS-1:0] = od_q;
        ADDR_W'(OFS_DBEN): rd_d[NUM_PINS-1:0] = dben_q;
        ADDR_W'(OFS_RSV0): rd_d = rsv0_q;
        ADDR_W'(OFS_RSV1): rd_d = rsv1_q;
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;
  assign dout_o  = dout_q;
  assign dir_o   = dir_q;
  assign od_o    = od_q;
  assign dben_o  = dben_q;
  assign thr_o   = thr_q;
endmodule

// File: rtl/dbgpio_port.sv
module dbgpio_port #(
  parameter int unsigned NUM_PINS      = 32,
  parameter int unsigned THR_W         = 16,
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned CLKS_PER_TICK = 12500
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  logic                           tick;
  logic [NUM_PINS-1:0]            raw_s, filt_q, status;
  logic [NUM_PINS-1:0]            dout_q, dir_q, od_q, dben_q;
  logic [NUM_PINS-1:0][THR_W-1:0] thr_q;

  dbgpio_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

  dbgpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_i), .q_o(raw_s));

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      dbgpio_filter #(.THR_W(THR_W)) u_filt (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .en_i(dben_q[p]),
        .thr_i(thr_q[p]), .raw_i(raw_s[p]), .filt_o(filt_q[p]));
    end
  endgenerate

  assign status = (dben_q & filt_q) | (~dben_q & raw_s);

  dbgpio_regs #(
    .NUM_PINS(NUM_PINS), .THR_W(THR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(bus_req_i), .we_i(bus_we_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .status_i(status), .dout_o(dout_q), .dir_o(dir_q), .od_o(od_q),
    .dben_o(dben_q), .thr_o(thr_q));

  // open-drain: release the pad for a 1, pull low for a 0
  assign pad_o    = dout_q & ~od_q;
  assign pad_oe_o = dir_q & (~od_q | ~dout_q);
endmodule

// File: rtl/dbgpio_port_chk.sv
module dbgpio_port_chk
  import dbgpio_pkg::*;
#(
  parameter int unsigned NUM_PINS      = 32,
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned CLKS_PER_TICK = 12500
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bus_req_i,
  input logic                bus_we_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [DATA_W-1:0]   bus_wdata_i,
  input logic [DATA_W-1:0]   bus_rdata_o,
  input logic [NUM_PINS-1:0] pad_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic                tick,
  input logic [NUM_PINS-1:0] filt_q,
  input logic [NUM_PINS-1:0] dben_q,
  input logic [NUM_PINS-1:0] dout_q,
  input logic [NUM_PINS-1:0] dir_q,
  input logic [NUM_PINS-1:0] od_q
);
  logic mapped;
  always_comb begin
    mapped = 1'b0;
    case (int'(bus_addr_i))
      OFS_DOUT, OFS_STAT, OFS_ISTAT, OFS_DIR,
      OFS_RSV0, OFS_RSV1, OFS_DBEN, OFS_ODEN: mapped = 1'b1;
      default: mapped = (int'(bus_addr_i) >= OFS_THR) && (bus_addr_i[1:0] == 2'b00)
                     && (int'(bus_addr_i) < OFS_THR + 4 * int'(NUM_PINS));
    endcase
  end

  p_idle_pads_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pad_oe_o == '0));

  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && int'(bus_addr_i) == OFS_DIR)
      |=> (dir_q == $past(bus_wdata_i[NUM_PINS-1:0])));

  p_od_never_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_o & pad_oe_o & od_q) == '0));

  p_input_no_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & ~dir_q) == '0));

  p_filt_on_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(tick) && $stable(dben_q)) |-> (((filt_q ^ $past(filt_q)) & dben_q) == '0));

  p_unmapped_rd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && !mapped) |=> (bus_rdata_o == '0));

  p_unmapped_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && (!mapped || int'(bus_addr_i) == OFS_STAT))
      |=> ($stable(dout_q) && $stable(dir_q) && $stable(od_q) && $stable(dben_q)));

  generate
    if (CLKS_PER_TICK > 1) begin : g_tick_chk
      p_tick_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick |=> !tick);
    end
  endgenerate
endmodule

bind dbgpio_port dbgpio_port_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLKS_PER_TICK(CLKS_PER_TICK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .pad_o(pad_o), .pad_oe_o(pad_oe_o), .tick(tick), .filt_q(filt_q),
  .dben_q(dben_q), .dout_q(dout_q), .dir_q(dir_q), .od_q(od_q));

// File: tb/dbgpio_port_test.sv
`timescale 1ns/1ps
module dbgpio_port_test;
  localparam int CPT = 4;
  localparam int THR = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] pad_in = '0, pad_out, pad_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbgpio_port #(.CLKS_PER_TICK(CPT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'hA5A5_3C3C; pats[3] = 32'h1234_8001;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1: reset state
    chk("R1 oe", pad_oe, 32'h0);
    rd_chk("R1 dout", 8'h00, 0);
    rd_chk("R1 dir", 8'h0C, 0);
    rd_chk("R1 dben", 8'h18, 0);
    rd_chk("R1 oden", 8'h1C, 0);
    rd_chk("R1 thr5", 8'h94, 0);

    // R2/R4: push-pull with mixed direction
    for (int i = 0; i < 4; i++) begin
      wr(8'h00, pats[i]);
      wr(8'h0C, pats[(i+2)%4] ^ 32'h0F0F_00FF);
      chk("R2 oe", pad_oe, pats[(i+2)%4] ^ 32'h0F0F_00FF);
      chk("R2 pad", pad_out & pad_oe, pats[i] & (pats[(i+2)%4] ^ 32'h0F0F_00FF));
      chk("R4 no drive", pad_oe & ~(pats[(i+2)%4] ^ 32'h0F0F_00FF), 0);
      rd_chk("R2 dout rb", 8'h00, pats[i]);
      rd_chk("R2 dir rb", 8'h0C, pats[(i+2)%4] ^ 32'h0F0F_00FF);
    end

    // R3: open-drain sweep, all outputs except top byte
    wr(8'h0C, 32'h00FF_FFFF);
    wr(8'h1C, 32'h0F0F_0F0F);
    for (int i = 0; i < 4; i++) begin
      wr(8'h00, pats[i]);
      chk("R3 oe", pad_oe, 32'h00FF_FFFF & (~32'h0F0F_0F0F | ~pats[i]));
      chk("R3 od low", pad_out & 32'h0F0F_0F0F, 0);
      chk("R3 pp pad", pad_out & ~32'h0F0F_0F0F, pats[i] & ~32'h0F0F_0F0F);
      chk("R4 top byte", pad_oe & 32'hFF00_0000, 0);
    end
    wr(8'h1C, 0);
    wr(8'h0C, 0);

    // R5: bypass status
    for (int i = 0; i < 4; i++) begin
      pad_in = pats[i] ^ 32'h5A5A_5A5A;
      cyc(2);
      rd_chk("R5 status", 8'h04, pats[i] ^ 32'h5A5A_5A5A);
    end

    // R8: thresholds at 0x80+4n, 16 bits
    for (int n = 0; n < 32; n++) wr(8'(8'h80 + 4*n), 32'hABCD_0000 | 32'(n*1031 + 7));
    for (int n = 0; n < 32; n++) rd_chk("R8 thr", 8'(8'h80 + 4*n), 32'((n*1031 + 7) & 16'hFFFF));

    // R6: filtered rise on pin 0, pin 1 unfiltered (R11)
    pad_in = 32'h0;
    wr(8'h80, THR);
    wr(8'h84, 32'h0000_0002);
    cyc(3);
    wr(8'h18, 32'h0000_0001);
    pad_in = 32'h0000_0003;
    cyc(4);
    rd_chk("R6 before thr", 8'h04, 32'h0000_0002);
    cyc(16);
    rd_chk("R6 after thr", 8'h04, 32'h0000_0003);

    // R7: three short glitches must not accumulate
    for (int g = 0; g < 3; g++) begin
      pad_in = 32'h0000_0002;
      cyc(7);
      pad_in = 32'h0000_0003;
      cyc(5);
    end
    cyc(20);
    rd_chk("R7 glitches", 8'h04, 32'h0000_0003);

    // R6: filtered fall
    pad_in = 32'h0;
    cyc(4);
    rd_chk("R6 fall early", 8'h04, 32'h0000_0001);
    cyc(16);
    rd_chk("R6 fall late", 8'h04, 32'h0);

    // R11: disabling filter restores direct follow
    pad_in = 32'h0000_0001;
    wr(8'h18, 0);
    cyc(2);
    rd_chk("R11 bypass", 8'h04, 32'h0000_0001);

    // R9: reserved and interrupt status
    wr(8'h10, 32'hDEAD_BEEF);
    wr(8'h14, 32'h0BAD_F00D);
    wr(8'h08, 32'hFFFF_FFFF);
    rd_chk("R9 rsv0", 8'h10, 32'hDEAD_BEEF);
    rd_chk("R9 rsv1", 8'h14, 32'h0BAD_F00D);
    rd_chk("R9 istat", 8'h08, 0);

    // R10: unmapped and status writes ignored
    wr(8'h00, 32'h0000_00F0);
    wr(8'h0C, 32'h0000_00FF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h7C, 32'hFFFF_FFFF);
    wr(8'h82, 32'hFFFF_FFFF);
    rd_chk("R10 rd 20", 8'h20, 0);
    rd_chk("R10 rd 7C", 8'h7C, 0);
    rd_chk("R10 rd 82", 8'h82, 0);
    rd_chk("R10 dout", 8'h00, 32'h0000_00F0);
    rd_chk("R10 dir", 8'h0C, 32'h0000_00FF);
    rd_chk("R10 oden", 8'h1C, 0);
    rd_chk("R10 dben", 8'h18, 0);
    rd_chk("R10 thr0", 8'h80, THR);
    chk("R10 pads", pad_out & pad_oe, 32'h0000_00F0);
    chk("R10 oe", pad_oe, 32'h0000_00FF);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule